// File: doc/BRIEF.md
# Thread-Partitioned Micro-op Queue

This block sits between instruction decode and the issue stage and buffers decoded micro-ops for up to two hardware threads. It has 32 entries. In two-thread mode each thread owns a fixed half of 16 entries. In single-thread mode thread 0 owns all 32 entries and thread 1 has no room. Decode writes up to two micro-ops per cycle for one thread. Issue takes up to two micro-ops per cycle, and both always come from the same thread. Decode can keep writing while issue is stalled, until the thread's own share is full. Full and empty flags for each thread go back to decode.

A two-state machine holds the operating mode:
- `MD_SOLO` is the reset state: single thread, thread 0 only.
- `MD_DUAL` is two threads with equal halves.

Transition `SOLO_TO_DUAL` fires when `dual_req` is high and the queue is idle. Transition `DUAL_TO_SOLO` fires when `dual_req` is low and the queue is idle. Idle means both threads hold no entries and no write is presented in that cycle. A request made at any other time leaves the mode unchanged. A flush input for each thread empties that thread's share in one cycle. The read side picks a thread by round-robin. When only one thread holds entries, that thread is picked.

Top module: `uop_split_queue`

## Requirements
- R1: After reset the mode is single-thread (`dual_on`=0), `empty`=2'b11, `full`=2'b10 and `rd_cnt`=0.
- R2: In single-thread mode thread 0 accepts up to 32 micro-ops and then raises `full[0]`. Writes tagged thread 1 are never accepted, and thread 1 reads full=1, empty=1.
- R3: In two-thread mode each thread holds at most 16 micro-ops and raises its own full flag at 16. Each thread fills independently of the other.
- R4: The mode follows `dual_req` only at a clock edge where both threads are empty and `wr_cnt`=0. At any other edge the mode is kept.
- R5: A write of `wr_cnt` micro-ops (1 or 2) is accepted, and `wr_accept` is 1, only if all of the following hold: the thread's free slots, counted at the start of the cycle, are at least `wr_cnt`; the thread exists in the current mode; and that thread is not being flushed. A write is taken whole or not at all.
- R6: Each thread returns its micro-ops in write order. `wr_uop0` is older than `wr_uop1`, and `rd_uop0` is older than `rd_uop1`.
- R7: `rd_cnt` equals the smaller of 2 and the selected thread's count. `rd_take` (clamped to `rd_cnt`) removes that many entries from thread `rd_tid` at the edge.
- R8: When both threads hold entries, the thread offered after a cycle with a nonzero take is the other thread. When only one thread holds entries, that thread is offered.
- R9: `flush[t]` empties thread t at the next edge and discards any write or take for t in that cycle. The other thread is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_req | input | 1 | Requested mode, 1 = two threads |
| flush | input | 2 | Per-thread discard, bit t = thread t |
| wr_cnt | input | 2 | Micro-ops offered this cycle (0, 1 or 2) |
| wr_tid | input | 1 | Thread of the offered micro-ops |
| wr_uop0 | input | UOP_W | Older offered micro-op |
| wr_uop1 | input | UOP_W | Younger offered micro-op |
| wr_accept | output | 1 | Offered write is taken this cycle |
| full | output | 2 | Per-thread share is full |
| empty | output | 2 | Per-thread share is empty |
| rd_tid | output | 1 | Thread offered to issue |
| rd_cnt | output | 2 | Micro-ops offered to issue (0 to 2) |
| rd_uop0 | output | UOP_W | Oldest offered micro-op |
| rd_uop1 | output | UOP_W | Second offered micro-op |
| rd_take | input | 2 | Micro-ops issue consumes this cycle |
| dual_on | output | 1 | Current mode, 1 = two threads |

## Verification
Some properties are checked by assertions on every cycle:
- each thread's count never exceeds its share;
- thread 1 holds nothing in single-thread mode;
- a flush always leaves the thread empty;
- a mode change only follows an idle cycle;
- consecutive reads alternate while both threads are occupied.

Other behaviour can only be shown by the bench's scenarios with expected data:
- write-to-read ordering of the data;
- rejection of a pair when exactly one slot remains;
- a write dropped under a simultaneous flush;
- a mode request ignored while entries are pending or a write is presented;
- the fallback to the single occupied thread.

// File: rtl/uq_pkg.sv
package uq_pkg;
    typedef enum logic {
        MD_SOLO = 1'b0,
        MD_DUAL = 1'b1
    } mode_e;
endpackage

// File: rtl/uq_mode_fsm.sv
module uq_mode_fsm
    import uq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dual_req,
    input  logic idle,
    output logic dual_on
);
    mode_e state, state_nx;

    // Next-state logic: a change is taken only when the queue is idle.
    always_comb begin
        state_nx = state;
        unique case (state)
            MD_SOLO: if (idle && dual_req)  state_nx = MD_DUAL;  // SOLO_TO_DUAL
            MD_DUAL: if (idle && !dual_req) state_nx = MD_SOLO;  // DUAL_TO_SOLO
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MD_SOLO;
        else        state <= state_nx;
    end

    // Outputs.
    always_comb begin
        dual_on = (state == MD_DUAL);
    end

    AST_MODE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> $past(idle)); // R4
endmodule

// File: rtl/uq_part.sv
module uq_part #(
    parameter int DEPTH = 32,
    parameter int TID   = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dual,
    input  logic [1:0]                 push,
    input  logic [1:0]                 pop,
    input  logic                       flush,
    output logic [$clog2(DEPTH):0]     count,
    output logic [$clog2(DEPTH):0]     cap,
    output logic [$clog2(DEPTH)-1:0]   wr_idx0,
    output logic [$clog2(DEPTH)-1:0]   wr_idx1,
    output logic [$clog2(DEPTH)-1:0]   rd_idx0,
    output logic [$clog2(DEPTH)-1:0]   rd_idx1
);
    localparam int HALF = DEPTH / 2;
    localparam int PW   = $clog2(DEPTH);
    localparam int CW   = PW + 1;

    logic [PW-1:0] head, tail, mask, base;

    // Share size, wrap mask and base offset depend on the mode.
    always_comb begin
        if (dual)           cap = CW'(HALF);
        else if (TID == 0)  cap = CW'(DEPTH);
        else                cap = '0;
        mask = dual ? PW'(HALF - 1) : PW'(DEPTH - 1);
        base = (dual && TID == 1) ? PW'(HALF) : '0;
        wr_idx0 = base + (tail & mask);
        wr_idx1 = base + ((tail + PW'(1)) & mask);
        rd_idx0 = base + (head & mask);
        rd_idx1 = base + ((head + PW'(1)) & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= (head + PW'(pop)) & mask;
            tail  <= (tail + PW'(push)) & mask;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_WITHIN_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap); // R3

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R9

    generate
        if (TID == 1) begin : g_t1
            AST_SOLO_T1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !dual |-> (count == '0)); // R2
        end
    endgenerate
endmodule

// File: rtl/uq_rd_arb.sv
module uq_rd_arb #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt0,
    input  logic [CW-1:0] cnt1,
    input  logic          take_ok,
    output logic          sel,
    output logic [1:0]    avail
);
    logic          last;
    logic          both;
    logic [CW-1:0] csel;

    always_comb begin
        both = (cnt0 != '0) && (cnt1 != '0);
        if (both)             sel = ~last;
        else if (cnt1 != '0)  sel = 1'b1;
        else                  sel = 1'b0;
        csel  = sel ? cnt1 : cnt0;
        avail = (csel >= CW'(2)) ? 2'd2 : csel[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       last <= 1'b1;
        else if (take_ok) last <= sel;
    end

    AST_RR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (both && take_ok) |=> (!both || sel != $past(sel))); // R8
endmodule

// File: rtl/uop_split_queue.sv
module uop_split_queue #(
    parameter int UOP_W = 16,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_req,
    input  logic [1:0]       flush,
    input  logic [1:0]       wr_cnt,
    input  logic             wr_tid,
    input  logic [UOP_W-1:0] wr_uop0,
    input  logic [UOP_W-1:0] wr_uop1,
    output logic             wr_accept,
    output logic [1:0]       full,
    output logic [1:0]       empty,
    output logic             rd_tid,
    output logic [1:0]       rd_cnt,
    output logic [UOP_W-1:0] rd_uop0,
    output logic [UOP_W-1:0] rd_uop1,
    input  logic [1:0]       rd_take,
    output logic             dual_on
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [CW-1:0]    cnt [2];
    logic [CW-1:0]    cap [2];
    logic [PW-1:0]    wi0 [2];
    logic [PW-1:0]    wi1 [2];
    logic [PW-1:0]    ri0 [2];
    logic [PW-1:0]    ri1 [2];
    logic [1:0]       push_n [2];
    logic [1:0]       pop_n  [2];
    logic [1:0]       take_c;
    logic [CW-1:0]    free_w;
    logic             idle;
    logic [UOP_W-1:0] mem [DEPTH];

    uq_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .dual_req(dual_req), .idle(idle), .dual_on(dual_on)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_part
            uq_part #(.DEPTH(DEPTH), .TID(g)) u_part (
                .clk(clk), .rst_n(rst_n), .dual(dual_on),
                .push(push_n[g]), .pop(pop_n[g]), .flush(flush[g]),
                .count(cnt[g]), .cap(cap[g]),
                .wr_idx0(wi0[g]), .wr_idx1(wi1[g]),
                .rd_idx0(ri0[g]), .rd_idx1(ri1[g])
            );
            always_comb begin
                push_n[g] = (wr_accept && wr_tid == 1'(g)) ? wr_cnt : 2'd0;
                pop_n[g]  = (rd_tid == 1'(g) && !flush[g]) ? take_c : 2'd0;
                full[g]   = (cnt[g] == cap[g]);
                empty[g]  = (cnt[g] == '0);
            end
        end
    endgenerate

    uq_rd_arb #(.CW(CW)) u_arb (
        .clk(clk), .rst_n(rst_n), .cnt0(cnt[0]), .cnt1(cnt[1]),
        .take_ok(take_c != 2'd0 && !flush[rd_tid]),
        .sel(rd_tid), .avail(rd_cnt)
    );

    always_comb begin
        free_w    = cap[wr_tid] - cnt[wr_tid];
        wr_accept = (wr_cnt != 2'd0) && (dual_on || !wr_tid) &&
                    !flush[wr_tid] && (free_w >= CW'(wr_cnt));
        take_c    = (rd_take > rd_cnt) ? rd_cnt : rd_take;
        idle      = (cnt[0] == '0) && (cnt[1] == '0) && (wr_cnt == 2'd0);
        rd_uop0   = mem[ri0[rd_tid]];
        rd_uop1   = mem[ri1[rd_tid]];
    end

    always_ff @(posedge clk) begin
        if (wr_accept) begin
            mem[wi0[wr_tid]] <= wr_uop0;
            if (wr_cnt == 2'd2) mem[wi1[wr_tid]] <= wr_uop1;
        end
    end

    AST_WRITE_NEEDS_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_on && wr_tid) |-> !wr_accept); // R2
endmodule

// File: tb/sim_uop_split_queue.sv
`timescale 1ns/1ps
module sim_uop_split_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_req = 1'b0;
    logic [1:0]  flush = 2'b00;
    logic [1:0]  wr_cnt = 2'd0;
    logic        wr_tid = 1'b0;
    logic [15:0] wr_uop0 = '0;
    logic [15:0] wr_uop1 = '0;
    logic        wr_accept;
    logic [1:0]  full, empty;
    logic        rd_tid;
    logic [1:0]  rd_cnt;
    logic [15:0] rd_uop0, rd_uop1;
    logic [1:0]  rd_take = 2'd0;
    logic        dual_on;

    int n_chk = 0;
    int n_bad = 0;

    uop_split_queue u0 (
        .clk(clk), .rst_n(rst_n), .dual_req(dual_req), .flush(flush),
        .wr_cnt(wr_cnt), .wr_tid(wr_tid), .wr_uop0(wr_uop0), .wr_uop1(wr_uop1),
        .wr_accept(wr_accept), .full(full), .empty(empty), .rd_tid(rd_tid),
        .rd_cnt(rd_cnt), .rd_uop0(rd_uop0), .rd_uop1(rd_uop1),
        .rd_take(rd_take), .dual_on(dual_on)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one edge; return 1 ns after it, then let inputs settle.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        wr_cnt = 2'd0; rd_take = 2'd0; flush = 2'b00;
        #1;
    endtask

    task automatic t_reset();
        chk(dual_on == 1'b0, "R1 mode", int'(dual_on), 0);
        chk(empty == 2'b11, "R1 empty", int'(empty), 3);
        chk(full == 2'b10, "R1 full", int'(full), 2);
        chk(rd_cnt == 2'd0, "R1 rd_cnt", int'(rd_cnt), 0);
    endtask

    task automatic t_solo();
        int bad = 0;
        for (int i = 0; i < 16; i++) begin
            wr_cnt = 2'd2; wr_tid = 1'b0;
            wr_uop0 = 16'h100 + 16'(2*i); wr_uop1 = 16'h101 + 16'(2*i);
            #1;
            if (!wr_accept) bad++;
            tick();
        end
        chk(bad == 0, "R2 solo pairs accepted", bad, 0);
        wr_cnt = 2'd0; #1;
        chk(full[0] == 1'b1, "R2 full at 32", int'(full[0]), 1);
        wr_cnt = 2'd1; wr_tid = 1'b0; #1;
        chk(wr_accept == 1'b0, "R5 write to full", int'(wr_accept), 0);
        wr_tid = 1'b1; #1;
        chk(wr_accept == 1'b0, "R2 thread1 rejected", int'(wr_accept), 0);
        chk(full[1] && empty[1], "R2 thread1 flags", int'({full[1], empty[1]}), 3);
        wr_cnt = 2'd0; dual_req = 1'b1;
        tick();
        chk(dual_on == 1'b0, "R4 busy keeps mode", int'(dual_on), 0);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            rd_take = 2'd2; #1;
            if (rd_cnt != 2'd2 || rd_tid != 1'b0 ||
                rd_uop0 != 16'h100 + 16'(2*i) || rd_uop1 != 16'h101 + 16'(2*i)) begin
                bad++;
                chk(0, "R6 R7 solo order", int'(rd_uop0), 16'h100 + 2*i);
            end
            tick();
        end
        chk(bad == 0, "R6 solo drain", bad, 0);
        idle_in();
        chk(empty[0] == 1'b1, "R7 drained", int'(empty[0]), 1);
    endtask

    task automatic t_mode();
        // dual_req is high and the queue is empty, but a write is presented.
        wr_cnt = 2'd1; wr_tid = 1'b0; wr_uop0 = 16'h0AA; #1;
        tick();
        idle_in();
        chk(dual_on == 1'b0, "R4 write blocks switch", int'(dual_on), 0);
        chk(empty[0] == 1'b0, "R4 write taken", int'(empty[0]), 0);
        flush = 2'b01; #1;
        tick();
        idle_in();
        chk(empty[0] == 1'b1, "R9 flush empties", int'(empty[0]), 1);
        chk(dual_on == 1'b0, "R4 not yet", int'(dual_on), 0);
        tick();
        chk(dual_on == 1'b1, "R4 switch when idle", int'(dual_on), 1);
        chk(full == 2'b00 && empty == 2'b11, "R3 dual flags",
            int'({full, empty}), 3);
    endtask

    task automatic t_dual();
        int bad = 0;
        for (int i = 0; i < 15; i++) begin
            wr_cnt = 2'd1; wr_tid = 1'b0; wr_uop0 = 16'h200 + 16'(i); #1;
            if (!wr_accept) bad++;
            tick();
        end
        chk(bad == 0, "R3 t0 singles", bad, 0);
        wr_cnt = 2'd2; wr_uop0 = 16'h20F; wr_uop1 = 16'h210; #1;
        chk(wr_accept == 1'b0, "R5 pair with one slot", int'(wr_accept), 0);
        tick();
        wr_cnt = 2'd1; #1;
        chk(wr_accept == 1'b1, "R5 single with one slot", int'(wr_accept), 1);
        tick();
        wr_cnt = 2'd0; #1;
        chk(full[0] == 1'b1, "R3 t0 full at 16", int'(full[0]), 1);
        chk(full[1] == 1'b0, "R3 t1 independent", int'(full[1]), 0);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            wr_cnt = 2'd2; wr_tid = 1'b1;
            wr_uop0 = 16'h300 + 16'(2*i); wr_uop1 = 16'h301 + 16'(2*i); #1;
            if (!wr_accept) bad++;
            tick();
        end
        chk(bad == 0, "R3 t1 pairs", bad, 0);
        idle_in();
        chk(full == 2'b11, "R3 both full", int'(full), 3);
    endtask

    task automatic t_rr();
        int e0 = 0;
        int e1 = 0;
        int prev = -1;
        int bad = 0;
        for (int i = 0; i < 4; i++) begin
            rd_take = 2'd2; #1;
            if (prev >= 0 && int'(rd_tid) == prev) begin
                bad++;
                chk(0, "R8 alternate", int'(rd_tid), 1 - prev);
            end
            prev = int'(rd_tid);
            if (rd_tid == 1'b0) begin
                chk(rd_uop0 == 16'h200 + 16'(e0) && rd_uop1 == 16'h200 + 16'(e0 + 1),
                    "R6 t0 data", int'(rd_uop0), 16'h200 + e0);
                e0 += 2;
            end else begin
                chk(rd_uop0 == 16'h300 + 16'(e1) && rd_uop1 == 16'h300 + 16'(e1 + 1),
                    "R6 t1 data", int'(rd_uop0), 16'h300 + e1);
                e1 += 2;
            end
            tick();
        end
        chk(bad == 0, "R8 four alternating reads", bad, 0);
        rd_take = 2'd0; flush = 2'b10;
        wr_cnt = 2'd1; wr_tid = 1'b1; wr_uop0 = 16'h3FF; #1;
        chk(wr_accept == 1'b0, "R9 write under flush", int'(wr_accept), 0);
        tick();
        idle_in();
        chk(empty == 2'b10, "R9 only t1 emptied", int'(empty), 2);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            rd_take = 2'd2; #1;
            if (rd_tid != 1'b0 || rd_cnt != 2'd2 || rd_uop0 != 16'h200 + 16'(e0)) begin
                bad++;
                chk(0, "R8 fallback t0", int'(rd_uop0), 16'h200 + e0);
            end
            e0 += 2;
            tick();
        end
        chk(bad == 0, "R8 fallback reads", bad, 0);
        rd_take = 2'd1; #1;
        chk(rd_cnt == 2'd2 && rd_uop0 == 16'h200 + 16'(e0), "R7 take one",
            int'(rd_uop0), 16'h200 + e0);
        tick();
        rd_take = 2'd2; #1;
        chk(rd_cnt == 2'd1, "R7 one left", int'(rd_cnt), 1);
        chk(rd_uop0 == 16'h200 + 16'(e0 + 1), "R6 last entry",
            int'(rd_uop0), 16'h200 + e0 + 1);
        tick();
        idle_in();
        chk(empty == 2'b11 && rd_cnt == 2'd0, "R7 clamped take empties",
            int'(empty), 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_solo();
        t_mode();
        t_dual();
        t_rr();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule